// File: doc/BRIEF.md
# Timekeeper register-file two-wire target

This block is the serial side of a timekeeping peripheral. It is a two-wire (I2C-style) target with a fixed 7-bit address. Through it a bus master reaches eight byte-wide registers: seven hold calendar and time fields (seconds, minutes, century/hours, weekday, day of month, month, year) and the eighth is a control byte. A 3-bit word pointer selects the register for the next byte. It is loaded by the first byte of a write and it steps forward after each acknowledged byte.

The raw bus lines are synchronised to the system clock and filtered, and START, repeated START and STOP are recognised from the filtered lines. The block drives the data line only as open-drain, by pulling it low. Three transfer shapes are served: a write of a pointer followed by data bytes; a pointer write, then a repeated START and a read; and a read with no pointer write, which continues from the stored pointer. Bit 7 of the control byte drives an open-drain output pin. A read-busy flag tells the timekeeping logic that a read of the time bytes is in progress. That logic loads new time values through a single-byte load port.

Top module: `rtc_i2c_target`

## Requirements
- R1: The target answers address byte 0xD0 (write) and 0xD1 (read), which is 7-bit address 0x68 with bit 0 as the direction bit (1 = read). It acknowledges by pulling SDA low for the whole high phase of the ninth clock.
- R2: An address byte with any other 7-bit address gets no acknowledge. The target then leaves SDA released and ignores all bits until the next START.
- R3: A START (SDA falls while SCL is high) restarts address reception from any state. This includes the middle of a byte, whose partial bits are then discarded. A STOP (SDA rises while SCL is high) returns the target to idle.
- R4: The target changes its SDA drive only while SCL is low. Read data is sent most significant bit first.
- R5: In a write, bits 2:0 of the first byte after the address load the pointer and bits 7:3 are ignored. Each later byte is stored at the pointer, and the pointer advances by one when that byte's acknowledge ends. The pointer wraps from 7 to 0.
- R6: In a read, the byte at the pointer is sent. The pointer advances (7 wraps to 0) only when the master acknowledges; after a master NACK it stays unchanged.
- R7: After a master NACK the target releases SDA and keeps it released until the next START or STOP.
- R8: A read not preceded by a pointer write starts at the pointer left by the previous transfer.
- R9: After reset the control register (address 7) is 0x80 and registers 0 to 6 are 0x00. The pin output pulls low exactly when bit 7 of the control register is 0.
- R10: The read-busy output is 1 from the acknowledge of a read address until the next STOP or START, but only while the pointer is between 0 and 6. At all other times it is 0.
- R11: A pulse on the load port writes the load data into the addressed register. If a bus data store falls in the same cycle, the bus byte is kept, whichever register the load port addresses.
- R12: The register output presents register i on bits 8i+7 to 8i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain drive) |
| pin_pull | output | 1 | 1 pulls the open-drain output pin low |
| read_busy | output | 1 | A read of registers 0 to 6 is in progress |
| tk_we | input | 1 | Load strobe from the timekeeping logic |
| tk_addr | input | 3 | Register addressed by the load strobe |
| tk_data | input | 8 | Byte written by the load strobe |
| regs_flat | output | 64 | All eight registers, register i at bits 8i+7:8i |

## Verification
A bus data store and a load from the timekeeping side can land on the same register in the same system cycle. The bench first runs a plain one-byte write and observes at the register output the cycle in which the byte appears, counted from the master's falling SCL edge. In later writes it places a single-cycle load pulse exactly on that cycle, and again one cycle after it. In the first case the bus byte must be kept. In the second case the loaded byte must be kept, because it arrives later.

// File: rtl/rtc_i2c_target.sv
module rtc_i2c_target #(
  parameter logic [6:0] DEV_ADDR  = 7'h68,
  parameter int         FILT_LEN  = 3,
  parameter logic [7:0] CTRL_INIT = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull,
  output logic        pin_pull,
  output logic        read_busy,
  input  logic        tk_we,
  input  logic [2:0]  tk_addr,
  input  logic [7:0]  tk_data,
  output logic [63:0] regs_flat
);

  localparam int NREG = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACKA, S_WPTR, S_WDAT, S_ACKW, S_RDAT, S_RACK
  } state_t;

  logic [1:0]          scl_s, sda_s;
  logic [FILT_LEN-1:0] scl_h, sda_h;
  logic                scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1;
      scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1;
      scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[FILT_LEN-2:0], scl_s[1]};
      sda_h <= {sda_h[FILT_LEN-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  logic start_det, stop_det, scl_rise, scl_fall;
  assign start_det = scl_p & scl_f & sda_p & ~sda_f;
  assign stop_det  = scl_p & scl_f & ~sda_p & sda_f;
  assign scl_rise  = ~scl_p & scl_f;
  assign scl_fall  = scl_p & ~scl_f;

  state_t     state;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [6:0] tx;
  logic [2:0] ptr;
  logic       rd_sess, mack, inc;
  logic [7:0] regs [NREG];

  logic [2:0] ptr_nx;
  logic       bus_we;
  assign ptr_nx = ptr + 3'd1;
  assign bus_we = (state == S_WDAT) & scl_fall & (cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
      rd_sess <= 1'b0; mack <= 1'b0; inc <= 1'b0; sda_pull <= 1'b0;
    end else if (start_det) begin
      state <= S_ADDR; cnt <= '0; sda_pull <= 1'b0; rd_sess <= 1'b0;
    end else if (stop_det) begin
      state <= S_IDLE; sda_pull <= 1'b0; rd_sess <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_WPTR, S_WDAT: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_f};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (state == S_ADDR) begin
              if (sh[7:1] == DEV_ADDR) begin
                state <= S_ACKA; sda_pull <= 1'b1; rd_sess <= sh[0];
              end else begin
                state <= S_IDLE;
              end
            end else begin
              state <= S_ACKW; sda_pull <= 1'b1;
              inc   <= (state == S_WDAT);
              if (state == S_WPTR) ptr <= sh[2:0];
            end
          end
        end
        S_ACKA: if (scl_fall) begin
          cnt <= '0;
          if (rd_sess) begin
            state <= S_RDAT; tx <= regs[ptr][6:0]; sda_pull <= ~regs[ptr][7];
          end else begin
            state <= S_WPTR; sda_pull <= 1'b0;
          end
        end
        S_ACKW: if (scl_fall) begin
          state <= S_WDAT; cnt <= '0; sda_pull <= 1'b0;
          if (inc) ptr <= ptr_nx;
        end
        S_RDAT: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              state <= S_RACK; sda_pull <= 1'b0;
            end else begin
              tx <= {tx[5:0], 1'b0}; sda_pull <= ~tx[6];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) mack <= ~sda_f;
          else if (scl_fall) begin
            cnt <= '0;
            if (mack) begin
              state <= S_RDAT; ptr <= ptr_nx;
              tx <= regs[ptr_nx][6:0]; sda_pull <= ~regs[ptr_nx][7];
            end else begin
              state <= S_IDLE; sda_pull <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= (i == NREG - 1) ? CTRL_INIT : 8'h00;
    end else if (bus_we) begin
      regs[ptr] <= sh;
    end else if (tk_we) begin
      regs[tk_addr] <= tk_data;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[8*g +: 8] = regs[g];
  end

  assign pin_pull  = ~regs[NREG-1][7];
  assign read_busy = rd_sess & (ptr != 3'd7);

  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_p && scl_f && !start_det && !stop_det) |=> $stable(sda_pull)) else $error("sda moved while scl high"); // R4
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull) else $error("sda held after start"); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_pull) else $error("sda pulled in idle"); // R7
  AST_PTR_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_fall |=> $stable(ptr)) else $error("pointer moved off a falling edge"); // R6

endmodule

// File: tb/rtc_i2c_target_bench.sv
module rtc_i2c_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 8;

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1, tk_we = 0;
  logic [2:0] tk_addr = 0;
  logic [7:0] tk_data = 0;
  logic sda_pull, pin_pull, read_busy;
  logic [63:0] regs_flat;
  wire sda_bus = sda_m & ~sda_pull;

  rtc_i2c_target u_rtc_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull(sda_pull), .pin_pull(pin_pull), .read_busy(read_busy),
    .tk_we(tk_we), .tk_addr(tk_addr), .tk_data(tk_data), .regs_flat(regs_flat));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  logic [7:0] m_regs [8];
  logic [7:0] wbuf [8];
  int m_ptr = 0;
  bit chk_en = 0;
  int last_fall = 0, f8 = -1, chg3 = -1, delta = 0;
  logic [7:0] prev3;

  task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] m_pack();
    logic [63:0] p;
    for (int i = 0; i < 8; i++) p[8*i +: 8] = m_regs[i];
    return p;
  endfunction

  always @(negedge clk) begin
    if (regs_flat[31:24] !== prev3) chg3 = cyc;
    prev3 = regs_flat[31:24];
    if (chk_en) begin
      check_eq("R12", "register image", regs_flat, m_pack());
      check_eq("R9", "pin pull", pin_pull, !m_regs[7][7]);
      check_eq("R10", "busy while idle", read_busy, 0);
      check_eq("R7", "sda released while idle", sda_pull, 0);
    end
  end

  task automatic hc(int n); repeat (n) @(negedge clk); endtask

  task automatic clk_bit(input bit b, output bit s);
    hc(HB); sda_m = b; hc(HB); scl = 1; hc(HB); s = sda_bus; hc(HB); scl = 0; last_fall = cyc;
  endtask

  task automatic bus_start();
    chk_en = 0;
    if (scl == 0) begin hc(HB); sda_m = 1; hc(HB); scl = 1; hc(2*HB); end
    sda_m = 0; hc(2*HB); scl = 0;
  endtask

  task automatic bus_stop();
    hc(HB); sda_m = 0; hc(HB); scl = 1; hc(2*HB); sda_m = 1; hc(4*HB);
  endtask

  task automatic settle(); hc(4); chk_en = 1; endtask

  task automatic send_byte(input logic [7:0] d, input bit mark, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    if (mark) f8 = last_fall;
    clk_bit(1, s);
    ack = !s;
  endtask

  task automatic addr(input logic [7:0] b, input bit exp, input string req);
    bit a;
    send_byte(b, 0, a);
    check_eq(req, "address acknowledge", a, exp);
  endtask

  task automatic read_byte(input bit mack, input bit exp_busy, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1, s); d[i] = s;
      if (i == 7) check_eq("R10", "busy during read", read_busy, exp_busy);
    end
    clk_bit(!mack, s);
  endtask

  task automatic wr_txn(input logic [7:0] ptr, input int n);
    bit a;
    bus_start();
    addr(8'hD0, 1, "R1");
    send_byte(ptr, 0, a);
    check_eq("R5", "pointer byte ack", a, 1);
    m_ptr = ptr % 8;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], 1, a);
      check_eq("R5", "data byte ack", a, 1);
      m_regs[m_ptr] = wbuf[k];
      m_ptr = (m_ptr + 1) % 8;
    end
    bus_stop();
  endtask

  task automatic read_seq(input int n, input string req);
    logic [7:0] d, e;
    for (int k = 0; k < n; k++) begin
      bit mack = (k != n - 1);
      e = m_regs[m_ptr];
      read_byte(mack, m_ptr != 7, d);
      check_eq(req, "read data", d, e);
      if (mack) m_ptr = (m_ptr + 1) % 8;
    end
    hc(HB);
    check_eq("R7", "sda released after nack", sda_pull, 0);
    check_eq("R10", "busy held until stop", read_busy, m_ptr != 7);
    bus_stop();
    check_eq("R10", "busy cleared by stop", read_busy, 0);
  endtask

  task automatic rd_cur(input int n, input string req);
    bus_start();
    addr(8'hD1, 1, "R1");
    read_seq(n, req);
  endtask

  task automatic rd_at(input logic [7:0] ptr, input int n, input string req);
    bit a;
    bus_start();
    addr(8'hD0, 1, "R1");
    send_byte(ptr, 0, a);
    check_eq("R5", "pointer byte ack", a, 1);
    m_ptr = ptr % 8;
    bus_start();
    addr(8'hD1, 1, "R3");
    read_seq(n, req);
  endtask

  task automatic tk_at(input int off, input logic [7:0] v);
    fork
      begin
        while (f8 < 0 || cyc != f8 + delta + off - 1) @(negedge clk);
        tk_addr = 3'd3; tk_data = v; tk_we = 1;
        @(negedge clk);
        tk_we = 0;
      end
    join_none
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_sim();
  end

  initial begin
    logic [7:0] d;
    bit a, s;
    for (int i = 0; i < 8; i++) m_regs[i] = (i == 7) ? 8'h80 : 8'h00;
    hc(5);
    check_eq("R9", "reset image", regs_flat, {8'h80, 56'h0});
    check_eq("R9", "reset pin", pin_pull, 0);
    check_eq("R10", "reset busy", read_busy, 0);
    rst_n = 1;
    settle();

    // R5 R1: pointer then three bytes
    wbuf = '{8'h23, 8'h15, 8'h06, 0, 0, 0, 0, 0};
    wr_txn(8'hFA, 3);  // bits 7:3 ignored, pointer 2
    settle();
    // R8 R6: current-pointer read, second byte nacked
    rd_cur(2, "R8");
    settle();
    rd_cur(1, "R6");
    settle();

    // R5 wrap and R9 pin
    wbuf = '{8'h99, 8'h00, 8'h59, 0, 0, 0, 0, 0};
    wr_txn(8'h06, 3);
    settle();
    check_eq("R9", "pin pulls with bit7 clear", pin_pull, 1);

    // R6 R10: read through wrap, busy drops at pointer 7
    rd_at(8'h00, 10, "R6");
    settle();

    // R2: foreign addresses
    bus_start();
    chk_en = 1;
    addr(8'hA0, 0, "R2");
    send_byte(8'h03, 0, a); check_eq("R2", "ignored byte ack", a, 0);
    send_byte(8'h77, 0, a); check_eq("R2", "ignored byte ack", a, 0);
    bus_stop();
    bus_start();
    chk_en = 1;
    addr(8'hD3, 0, "R2");
    read_byte(1, 0, d);
    check_eq("R2", "no data from foreign read", d, 8'hFF);
    // R3: repeated START after mismatch is answered
    bus_start();
    addr(8'hD1, 1, "R3");
    read_seq(1, "R8");
    settle();

    // R3: START in mid-byte discards partial bits
    bus_start();
    addr(8'hD0, 1, "R1");
    send_byte(8'h01, 0, a);
    m_ptr = 1;
    for (int i = 0; i < 4; i++) clk_bit(0, s);
    bus_start();
    addr(8'hD1, 1, "R3");
    read_seq(1, "R3");
    settle();

    // R9: restore control bit
    wbuf = '{8'h80, 0, 0, 0, 0, 0, 0, 0};
    wr_txn(8'h07, 1);
    settle();
    check_eq("R9", "pin released", pin_pull, 0);

    // R11: plain load
    chk_en = 0;
    tk_addr = 3'd0; tk_data = 8'h42; tk_we = 1; hc(1); tk_we = 0;
    m_regs[0] = 8'h42;
    settle();

    // R11: measure store cycle, then collide
    wbuf = '{8'h11, 0, 0, 0, 0, 0, 0, 0};
    f8 = -1;
    wr_txn(8'h03, 1);
    delta = chg3 - f8;
    settle();
    f8 = -1;
    tk_at(0, 8'h44);
    wbuf = '{8'h22, 0, 0, 0, 0, 0, 0, 0};
    wr_txn(8'h03, 1);
    check_eq("R11", "bus wins same cycle", regs_flat[31:24], 8'h22);
    settle();
    f8 = -1;
    tk_at(1, 8'h44);
    wbuf = '{8'h33, 0, 0, 0, 0, 0, 0, 0};
    wr_txn(8'h03, 1);
    check_eq("R11", "later load kept", regs_flat[31:24], 8'h44);
    m_regs[3] = 8'h44;
    settle();
    rd_at(8'h03, 2, "R11");
    settle();
    hc(10);
    finish_sim();
  end
endmodule